// File: doc/BRIEF.md
# Configurable Timer/Counter with Capture

This block is a 16-bit timer/counter whose register can be split into two 8-bit halves or used as one 16-bit unit. Each part counts either prescaled ticks of the system-clock tick input or rising edges on an external event input. A 2-bit mode select chooses the arrangement. An 8-bit prescaler divides the tick input by a programmable amount.

Each counting part compares its value with a programmable match value. On a hit it returns to zero and raises a sticky interrupt flag. Two capture trigger inputs copy the live count into a capture register. In the split modes each trigger serves its own byte. In the joined modes one trigger loads all 16 bits together.

Register updates arrive as simple write strobes with data. The external event and capture inputs may be asynchronous to the clock.

Top module: `cfg_timer_capture`

## Requirements
- R1: While `rst_ni` is low, `count_o`, `cap_o` and `irq_o` are all zero.
- R2: The prescaler reload value N gives one count step per N+1 cycles in which `tick_i` is high. The first step comes on the first tick after a mode change or reset. With `tick_i` low, a prescaled part holds its value.
- R3: `mode_i` encoding: 0 = two 8-bit prescaled timers; 1 = low byte prescaled timer and high byte external-event counter; 2 = one 16-bit prescaled timer; 3 = one 16-bit external-event counter with no prescaler.
- R4: In modes 0 and 1 the halves are independent, and a low byte going from 255 to 0 leaves the high byte unchanged. In modes 2 and 3 the low byte carries into the high byte.
- R5: A part whose count equals its match value when a step arrives goes to zero instead of incrementing, and sets its flag. `match_i[7:0]` belongs to the low byte and `irq_o[0]`, and `match_i[15:8]` to the high byte and `irq_o[1]`. In modes 2 and 3 the full 16 bits are compared, `irq_o[0]` is used, and `irq_o[1]` is never set.
- R6: Flags stay set until a write with `flag_clr_we_i` high and a 1 in the matching bit of `flag_clr_i`. Bits written as 0 have no effect. A set in the same cycle wins over the clear.
- R7: `ext_cnt_i` and `cap_i` pass through two synchroniser flops. Only a 0-to-1 change acts, and it takes effect on the third rising clock edge after the input rises. An input held high acts once.
- R8: In modes 0 and 1, a rising `cap_i[0]` loads `cap_o[7:0]` from the low byte, and a rising `cap_i[1]` loads `cap_o[15:8]` from the high byte. Each takes the count as it stood before that edge's update.
- R9: In modes 2 and 3, a rising `cap_i[0]` loads all 16 bits of `cap_o` in one cycle, and `cap_i[1]` is ignored.
- R10: A change of `mode_i` zeroes the counter and prescaler on the next edge, with no step in that cycle. The flags and `cap_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Tick enable from the system clock divider |
| ext_cnt_i | input | 1 | External event input, asynchronous |
| cap_i | input | 2 | Capture triggers, asynchronous |
| mode_i | input | 2 | Mode select |
| psc_we_i | input | 1 | Write strobe for the prescaler reload |
| psc_reload_i | input | 8 | Prescaler reload value N |
| match_we_i | input | 1 | Write strobe for the match values |
| match_i | input | 16 | Match values, high byte and low byte |
| flag_clr_we_i | input | 1 | Write strobe for clearing flags |
| flag_clr_i | input | 2 | Flag clear mask, 1 clears |
| count_o | output | 16 | Live counter value |
| cap_o | output | 16 | Capture register |
| irq_o | output | 2 | Sticky match flags |

## Verification
The counting path is driven with a continuous tick and with a gapped tick, at several reload values. These runs separate a correct divide by N+1 from a divide by N, and show whether gaps in the tick stall the prescaler. External events are sent as one-cycle pulses, as short bursts and as levels held high. This separates true edge detection from level counting and shows the latency of the synchroniser. Capture triggers are exercised in split and joined modes to show which bytes load. A long mixed run then adds random match writes, flag clears and mode switches. Its results are compared each cycle with a behavioural model, which exposes errors in carries, match-clear placement and flag priority.

// File: rtl/tmr_cap_pkg.sv
package tmr_cap_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL8 = 2'd0,
    MODE_T8_C8 = 2'd1,
    MODE_T16   = 2'd2,
    MODE_C16   = 2'd3
  } tmr_mode_e;

  function automatic logic mode_wide(tmr_mode_e m);
    return (m == MODE_T16) || (m == MODE_C16);
  endfunction
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] reload_i,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;

  assign pulse_o = tick_i & ~clr_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
  end
endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         zero_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (clr_i || zero_i) cnt_o <= '0;
    else if (inc_i)           cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cfg_timer_capture.sv
module cfg_timer_capture
  import tmr_cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ext_cnt_i,
  input  logic [1:0]       cap_i,
  input  logic [1:0]       mode_i,
  input  logic             psc_we_i,
  input  logic [PSC_W-1:0] psc_reload_i,
  input  logic             match_we_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic             flag_clr_we_i,
  input  logic [1:0]       flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cap_o,
  output logic [1:0]       irq_o
);
  localparam int HALF_W  = CNT_W / 2;
  localparam int N_ASYNC = 3;

  tmr_mode_e        mode_q;
  logic [PSC_W-1:0] reload_q;
  logic [CNT_W-1:0] match_q;
  logic             mode_chg, wide, psc_pulse;
  logic [N_ASYNC-1:0] async_in, rise;
  logic             ext_rise;
  logic [1:0]       cap_rise;

  assign mode_chg = (mode_i != mode_q);
  assign wide     = mode_wide(mode_q);

  // index 0: external events, 1..2: capture triggers
  assign async_in = {cap_i, ext_cnt_i};

  for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(async_in[g]),
      .rise_o (rise[g])
    );
  end

  assign ext_rise = rise[0];
  assign cap_rise = rise[2:1];

  tmr_prescaler #(.W(PSC_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (mode_chg),
    .tick_i  (tick_i),
    .reload_i(reload_q),
    .pulse_o (psc_pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_DUAL8;
      reload_q <= '0;
      match_q  <= '0;
    end else begin
      mode_q <= tmr_mode_e'(mode_i);
      if (psc_we_i)   reload_q <= psc_reload_i;
      if (match_we_i) match_q  <= match_i;
    end
  end

  // step enables per half
  logic en_lo, en_hi;
  assign en_lo = ~mode_chg & ((mode_q == MODE_C16)   ? ext_rise : psc_pulse);
  assign en_hi = ~mode_chg & ((mode_q == MODE_T8_C8) ? ext_rise : psc_pulse);

  logic [HALF_W-1:0] cnt_h [2];
  logic [1:0]        h_inc, h_zero;
  logic              hit_lo, hit_hi, hit_all;

  assign hit_lo  = (cnt_h[0] == match_q[HALF_W-1:0]);
  assign hit_hi  = (cnt_h[1] == match_q[CNT_W-1:HALF_W]);
  assign hit_all = hit_lo & hit_hi;

  always_comb begin
    if (wide) begin
      h_zero[0] = en_lo & hit_all;
      h_inc[0]  = en_lo & ~hit_all;
      h_zero[1] = h_zero[0];
      h_inc[1]  = h_inc[0] & (&cnt_h[0]);
    end else begin
      h_zero[0] = en_lo & hit_lo;
      h_inc[0]  = en_lo & ~hit_lo;
      h_zero[1] = en_hi & hit_hi;
      h_inc[1]  = en_hi & ~hit_hi;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_half
    tmr_half #(.W(HALF_W)) u_half (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (mode_chg),
      .zero_i(h_zero[g]),
      .inc_i (h_inc[g]),
      .cnt_o (cnt_h[g])
    );
  end

  assign count_o = {cnt_h[1], cnt_h[0]};

  // sticky flags, set has priority over clear
  logic [1:0] flag_set;
  assign flag_set = {h_zero[1] & ~wide, h_zero[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else irq_o <= (irq_o & ~({2{flag_clr_we_i}} & flag_clr_i)) | flag_set;
  end

  // capture: joined modes load both bytes from trigger 0
  logic ld_lo, ld_hi;
  assign ld_lo = cap_rise[0];
  assign ld_hi = wide ? cap_rise[0] : cap_rise[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_o <= '0;
    else begin
      if (ld_lo) cap_o[HALF_W-1:0]     <= cnt_h[0];
      if (ld_hi) cap_o[CNT_W-1:HALF_W] <= cnt_h[1];
    end
  end
endmodule

// File: rtl/tmr_cap_checker.sv
module tmr_cap_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [1:0]       cap_i,
  input logic [1:0]       mode_i,
  input logic             flag_clr_we_i,
  input logic [1:0]       flag_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] cap_o,
  input logic [1:0]       irq_o
);
  localparam int HALF_W = CNT_W / 2;

  a_r2_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'd0 || mode_i == 2'd2) && mode_i == $past(mode_i) && !tick_i)
      |=> $stable(count_o));

  a_r5_lo_flag_clears_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[0]) |-> (count_o[HALF_W-1:0] == '0));

  a_r5_hi_flag_clears_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[1]) |-> (count_o[CNT_W-1:HALF_W] == '0));

  a_r5_hi_flag_idle_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && $past(mode_i[1]) && !irq_o[1]) |=> !irq_o[1]);

  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o[0] && !(flag_clr_we_i && flag_clr_i[0])) |=> irq_o[0]);

  a_r8_cap_needs_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_o) |-> ($past(cap_i, 3) != 2'b00));
endmodule

bind cfg_timer_capture tmr_cap_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .cap_i        (cap_i),
  .mode_i       (mode_i),
  .flag_clr_we_i(flag_clr_we_i),
  .flag_clr_i   (flag_clr_i),
  .count_o      (count_o),
  .cap_o        (cap_o),
  .irq_o        (irq_o)
);

// File: tb/cfg_timer_capture_bench.sv
module cfg_timer_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, ext = 1'b0;
  logic [1:0]  capv = 2'b00, mode = 2'b00;
  logic        pwe = 1'b0, mwe = 1'b0, fcwe = 1'b0;
  logic [7:0]  prel = 8'd0;
  logic [15:0] mval = 16'd0;
  logic [1:0]  fclr = 2'b00;
  logic [15:0] count, capo;
  logic [1:0]  irq;

  int checks = 0, failures = 0;
  string phase = "R1 reset";

  always #4 clk = ~clk;

  cfg_timer_capture u_cfg_timer_capture (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ext_cnt_i(ext), .cap_i(capv),
    .mode_i(mode), .psc_we_i(pwe), .psc_reload_i(prel), .match_we_i(mwe),
    .match_i(mval), .flag_clr_we_i(fcwe), .flag_clr_i(fclr),
    .count_o(count), .cap_o(capo), .irq_o(irq)
  );

  // behavioural reference
  int m_mode, m_psc, m_rel, m_mat, m_cnt, m_cap, f0, f1;
  logic [2:0] h_ext, h_c0, h_c1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_psc = 0; m_rel = 0; m_mat = 0; m_cnt = 0; m_cap = 0;
      f0 = 0; f1 = 0; h_ext = '0; h_c0 = '0; h_c1 = '0;
    end else begin
      bit r_ext, r_c0, r_c1, pulse, en_lo, en_hi, en;
      int lo, hi;
      r_ext = h_ext[1] & ~h_ext[2]; h_ext = {h_ext[1:0], ext};
      r_c0  = h_c0[1] & ~h_c0[2];   h_c0  = {h_c0[1:0], capv[0]};
      r_c1  = h_c1[1] & ~h_c1[2];   h_c1  = {h_c1[1:0], capv[1]};
      if (m_mode >= 2) begin
        if (r_c0) m_cap = m_cnt;
      end else begin
        if (r_c0) m_cap = (m_cap & 'hFF00) | (m_cnt & 'hFF);
        if (r_c1) m_cap = (m_cap & 'hFF) | (m_cnt & 'hFF00);
      end
      if (fcwe && fclr[0]) f0 = 0;
      if (fcwe && fclr[1]) f1 = 0;
      if (int'(mode) != m_mode) begin
        m_mode = int'(mode); m_cnt = 0; m_psc = 0;
      end else begin
        pulse = tick && (m_psc == 0);
        if (tick) m_psc = pulse ? m_rel : m_psc - 1;
        if (m_mode < 2) begin
          lo = m_cnt & 'hFF; hi = m_cnt >> 8;
          en_lo = pulse;
          en_hi = (m_mode == 0) ? pulse : r_ext;
          if (en_lo) begin
            if (lo == (m_mat & 'hFF)) begin lo = 0; f0 = 1; end
            else lo = (lo + 1) & 'hFF;
          end
          if (en_hi) begin
            if (hi == (m_mat >> 8)) begin hi = 0; f1 = 1; end
            else hi = (hi + 1) & 'hFF;
          end
          m_cnt = hi * 256 + lo;
        end else begin
          en = (m_mode == 2) ? pulse : r_ext;
          if (en) begin
            if (m_cnt == m_mat) begin m_cnt = 0; f0 = 1; end
            else m_cnt = (m_cnt + 1) & 'hFFFF;
          end
        end
      end
      if (pwe) m_rel = int'(prel);
      if (mwe) m_mat = int'(mval);
    end
  end

  task automatic check_val(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check_val("count R3", int'(count), m_cnt);
    check_val("cap R8", int'(capo), m_cap);
    check_val("irq R5", int'(irq), f1 * 2 + f0);
  endtask

  // one clock: wait for negedge, compare, leave caller to drive
  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_n) compare_all();
    end
  endtask

  task automatic clear_strobes();
    pwe = 1'b0; mwe = 1'b0; fcwe = 1'b0;
  endtask

  int wd = 0;
  initial begin
    while (wd < 200000) begin @(posedge clk); wd++; end
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", wd);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] keep_cap;
    logic [1:0]  keep_irq;
    repeat (3) @(negedge clk);
    check_val("R1 count in reset", int'(count), 0);
    check_val("R1 cap in reset", int'(capo), 0);
    check_val("R1 irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    cyc(2);

    // R2 mode 2 prescaler with continuous then gapped tick
    phase = "R2 mode2 prescale";
    pwe = 1'b1; prel = 8'd3; mwe = 1'b1; mval = 16'hFFFF;
    cyc(); clear_strobes(); mode = 2'd2; tick = 1'b1;
    cyc(); // mode change edge
    cyc(20);
    check_val("R2 count after 20 ticks div4", int'(count), 5);
    for (int i = 0; i < 40; i++) begin tick = (i % 3 == 0); cyc(); end
    tick = 1'b0; cyc(5);
    check_val("R2 count holds without tick", int'(count), m_cnt);

    // R4 carry in 16-bit mode, reload 0
    phase = "R4 mode2 carry";
    pwe = 1'b1; prel = 8'd0; cyc(); clear_strobes();
    mode = 2'd0; cyc(); mode = 2'd2; tick = 1'b1; cyc();
    cyc(260);
    check_val("R4 count carries into high byte", int'(count), 260);

    // R5 match in mode 0, R10 mode change zeroing
    phase = "R5 mode0 match";
    tick = 1'b0; mwe = 1'b1; mval = 16'h0203; cyc(); clear_strobes();
    mode = 2'd0; fcwe = 1'b1; fclr = 2'b11; cyc(); clear_strobes();
    tick = 1'b1; cyc(4); tick = 1'b0; cyc();
    check_val("R5 count after four steps", int'(count), 16'h0100);
    check_val("R5 both flags set", int'(irq), 2'b11);

    // R6 write-1-clear
    phase = "R6 flag clear";
    fcwe = 1'b1; fclr = 2'b00; cyc(); clear_strobes(); cyc();
    check_val("R6 zero mask keeps flags", int'(irq), 2'b11);
    fcwe = 1'b1; fclr = 2'b01; cyc(); clear_strobes(); cyc();
    check_val("R6 clear low flag only", int'(irq), 2'b10);
    fcwe = 1'b1; fclr = 2'b10; cyc(); clear_strobes(); cyc();
    check_val("R6 clear high flag", int'(irq), 2'b00);

    // R4 independent halves in mode 0
    phase = "R4 mode0 independent";
    mwe = 1'b1; mval = 16'h05FF; cyc(); clear_strobes();
    tick = 1'b1; cyc(300); tick = 1'b0; cyc();

    // R7 mode 1 external events
    phase = "R7 mode1 ext";
    mwe = 1'b1; mval = 16'h33FF; cyc(); clear_strobes();
    mode = 2'd1; cyc(); cyc(2);
    ext = 1'b1; cyc(6); ext = 1'b0; cyc(6);
    check_val("R7 held level counts once", int'(count), 16'h0100);
    for (int i = 0; i < 3; i++) begin ext = 1'b1; cyc(); ext = 1'b0; cyc(2); end
    cyc(4);
    check_val("R7 three pulses", int'(count), 16'h0400);

    // R8 split capture
    phase = "R8 split capture";
    capv = 2'b10; cyc(); capv = 2'b00; cyc(5);
    check_val("R8 high byte captured", int'(capo[15:8]), 8'h04);
    tick = 1'b1; cyc(7); tick = 1'b0;
    capv = 2'b01; cyc(); capv = 2'b00; cyc(5);
    check_val("R8 low byte captured", int'(capo[7:0]), m_cnt & 'hFF);
    check_val("R8 high byte kept", int'(capo[15:8]), 8'h04);

    // R9 16-bit capture in mode 3
    phase = "R9 mode3 capture";
    mwe = 1'b1; mval = 16'hFFFF; cyc(); clear_strobes();
    mode = 2'd3; cyc(); cyc(3);
    for (int i = 0; i < 5; i++) begin ext = 1'b1; cyc(); ext = 1'b0; cyc(); end
    cyc(4);
    check_val("R9 counted five events", int'(count), 5);
    keep_cap = capo;
    capv = 2'b10; cyc(); capv = 2'b00; cyc(5);
    check_val("R9 trigger 1 ignored", int'(capo), int'(keep_cap));
    capv = 2'b01; cyc(); capv = 2'b00; cyc(5);
    check_val("R9 full capture", int'(capo), 5);

    // R10 mode change mid-count
    phase = "R10 mode change";
    keep_cap = capo; keep_irq = irq;
    mode = 2'd0; cyc();
    check_val("R10 count zeroed", int'(count), 0);
    check_val("R10 cap kept", int'(capo), int'(keep_cap));
    check_val("R10 flags kept", int'(irq), int'(keep_irq));

    // mixed random run covering R3 R5 R7
    phase = "R3 R5 R7 mixed";
    for (int i = 0; i < 2500; i++) begin
      tick = ($urandom % 2) == 0;
      ext  = ($urandom % 3) == 0;
      capv = {($urandom % 9) == 0, ($urandom % 9) == 0};
      pwe  = ($urandom % 50) == 0; prel = 8'($urandom % 4);
      mwe  = ($urandom % 60) == 0;
      mval = {8'($urandom % 3), 8'($urandom % 12)};
      fcwe = ($urandom % 20) == 0; fclr = 2'($urandom);
      if (($urandom % 150) == 0) mode = 2'($urandom);
      cyc();
    end
    clear_strobes(); cyc(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule